// File: doc/BRIEF.md
# Speculative Load Address Tracker

This block lets a pipeline hoist a load above older stores whose addresses are not yet known to be disjoint. When such a hoisted load executes, it records its destination register tag, start address and access size in a small fully associative table. Every committed store is compared against all live records in parallel. Any record whose byte range shares at least one byte with the store is dropped.

When the pipeline reaches the point where the load originally sat, it issues a check for the register tag. The response arrives one cycle later and says whether the record is still live. If it is live, the speculated value may be kept. If it is gone, the response asks for either a plain reload or a branch to recovery code, depending on the check flavour.

A speculative load that carried a deferred fault must not leave a usable record. A flush input empties the table, for example on a context switch. When the table is full, a round-robin pointer picks the slot to overwrite. Losing a record this way only causes an extra reload.

Top module: `ldaddr_guard`

## Requirements
- R1: Directly after reset, `chk_done_o`, `chk_hit_o`, `chk_reload_o` and `chk_recover_o` are 0, and a check for any tag reports a miss.
- R2: A check with `chk_valid_i` high gives its response in the following cycle with `chk_done_o` = 1. The response shows a hit when a record for that tag was inserted earlier and is still live.
- R3: A record covers the bytes from `addr` up to `addr + 2**lgsz - 1`. A store covering bytes `[st_addr, st_addr + 2**st_lgsz)` removes every record whose range shares at least one byte with it.
- R4: A store whose byte range only touches a record's range (it ends where the record starts, or starts where the record ends) leaves that record live.
- R5: A check with `chk_recover_i` = 0 that misses raises only `chk_reload_o`. A check with `chk_recover_i` = 1 that misses raises only `chk_recover_o`. A check that hits raises neither.
- R6: Inserting a tag that is already present replaces that record's address and size. A store that overlaps only the old range then has no effect, and a store that overlaps the new range removes the record.
- R7: When all 16 slots are live and a new tag is inserted, the victim slot is chosen round-robin. The pointer starts at slot 0 after reset and advances by one on each eviction. Empty slots are filled lowest-index first.
- R8: When a store and a check fall in the same cycle, the store's removal is applied before the lookup.
- R9: An insert with `ins_fault_i` = 1 creates no record and removes any existing record for that tag, so a later check for the tag misses.
- R10: `flush_i` removes every record. A check in the flush cycle or in any later cycle misses until the tag is inserted again.
- R11: A check and an insert of the same tag in the same cycle are ordered as check first. The check sees the table as it was before that insert.
- R12: An insert and an overlapping store in the same cycle are ordered as store first, so the new record stays live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| flush_i | input | 1 | Remove all records |
| ins_valid_i | input | 1 | Record a hoisted load |
| ins_fault_i | input | 1 | The hoisted load carries a deferred fault |
| ins_tag_i | input | 7 | Destination register tag of the load |
| ins_addr_i | input | 64 | Load start address |
| ins_lgsz_i | input | 4 | log2 of the load size in bytes |
| st_valid_i | input | 1 | Committed store present |
| st_addr_i | input | 64 | Store start address |
| st_lgsz_i | input | 4 | log2 of the store size in bytes |
| chk_valid_i | input | 1 | Check request |
| chk_recover_i | input | 1 | Check flavour: 0 reload, 1 recovery branch |
| chk_tag_i | input | 7 | Register tag being checked |
| chk_done_o | output | 1 | Check response valid |
| chk_hit_o | output | 1 | Record still live |
| chk_reload_o | output | 1 | Load must be reissued |
| chk_recover_o | output | 1 | Branch to recovery code |

## Verification
The overlap comparison is tried with stores that fall inside a record, cover it completely, hit only its last byte, and only touch it from either side. This separates a correct half-open range test from one that is off by one at either end. Replacement is tried by overwriting a live tag, so that old and new ranges can be told apart, and by filling all slots and evicting twice, which exposes a pointer that fails to start at zero or to advance. Same-cycle combinations of store, check, insert and flush show the ordering rules. Faulting inserts are tried both on a present tag and on an absent tag.

// File: rtl/ldg_pkg.sv
package ldg_pkg;
    localparam int unsigned LDG_ENTRIES = 16;
    localparam int unsigned LDG_TAG_W   = 7;
    localparam int unsigned LDG_ADDR_W  = 64;
    localparam int unsigned LDG_LGSZ_W  = 4;

    typedef enum logic {
        CHK_RELOAD  = 1'b0,
        CHK_RECOVER = 1'b1
    } chk_flavour_e;
endpackage

// File: rtl/ldg_overlap.sv
module ldg_overlap #(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned LGSZ_W = 4
) (
    input  logic [ADDR_W-1:0] a_base_i,
    input  logic [LGSZ_W-1:0] a_lgsz_i,
    input  logic [ADDR_W-1:0] b_base_i,
    input  logic [LGSZ_W-1:0] b_lgsz_i,
    output logic              hit_o
);
    localparam int unsigned EW = ADDR_W + 1;

    logic [EW-1:0] a_lo, a_hi, b_lo, b_hi;

    // ranges are half open; one extra bit keeps the end from wrapping
    always_comb begin
        a_lo  = {1'b0, a_base_i};
        b_lo  = {1'b0, b_base_i};
        a_hi  = a_lo + (EW'(1) << a_lgsz_i);
        b_hi  = b_lo + (EW'(1) << b_lgsz_i);
        hit_o = (a_lo < b_hi) && (b_lo < a_hi);
    end
endmodule

// File: rtl/ldg_tag_match.sv
module ldg_tag_match #(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned TAG_W   = 7,
    parameter int unsigned IDX_W   = 4
) (
    input  logic [ENTRIES-1:0]            vld_i,
    input  logic [ENTRIES-1:0][TAG_W-1:0] tags_i,
    input  logic [TAG_W-1:0]              key_i,
    output logic                          hit_o,
    output logic [IDX_W-1:0]              idx_o
);
    // lowest matching slot wins
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = int'(ENTRIES) - 1; i >= 0; i--) begin
            if (vld_i[i] && (tags_i[i] == key_i)) begin
                hit_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/ldg_slot_pick.sv
module ldg_slot_pick #(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned IDX_W   = 4
) (
    input  logic [ENTRIES-1:0] vld_i,
    output logic               free_any_o,
    output logic [IDX_W-1:0]   free_idx_o
);
    always_comb begin
        free_any_o = 1'b0;
        free_idx_o = '0;
        for (int i = int'(ENTRIES) - 1; i >= 0; i--) begin
            if (!vld_i[i]) begin
                free_any_o = 1'b1;
                free_idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/ldaddr_guard.sv
module ldaddr_guard
    import ldg_pkg::*;
#(
    parameter int unsigned ENTRIES = LDG_ENTRIES,
    parameter int unsigned TAG_W   = LDG_TAG_W,
    parameter int unsigned ADDR_W  = LDG_ADDR_W,
    parameter int unsigned LGSZ_W  = LDG_LGSZ_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              flush_i,
    input  logic              ins_valid_i,
    input  logic              ins_fault_i,
    input  logic [TAG_W-1:0]  ins_tag_i,
    input  logic [ADDR_W-1:0] ins_addr_i,
    input  logic [LGSZ_W-1:0] ins_lgsz_i,
    input  logic              st_valid_i,
    input  logic [ADDR_W-1:0] st_addr_i,
    input  logic [LGSZ_W-1:0] st_lgsz_i,
    input  logic              chk_valid_i,
    input  logic              chk_recover_i,
    input  logic [TAG_W-1:0]  chk_tag_i,
    output logic              chk_done_o,
    output logic              chk_hit_o,
    output logic              chk_reload_o,
    output logic              chk_recover_o
);
    localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0][TAG_W-1:0]  tag;
        logic [ENTRIES-1:0][ADDR_W-1:0] base;
        logic [ENTRIES-1:0][LGSZ_W-1:0] lgsz;
        logic [IDX_W-1:0]               rr;
        logic                           done;
        logic                           hit;
        logic                           reload;
        logic                           recover;
    } state_t;

    state_t s_q, s_d;

    logic [ENTRIES-1:0] st_ov;
    logic [ENTRIES-1:0] vld_after_st;
    logic               chk_hit_w;
    logic [IDX_W-1:0]   chk_idx_w;
    logic               ins_hit_w;
    logic [IDX_W-1:0]   ins_idx_w;
    logic               free_any_w;
    logic [IDX_W-1:0]   free_idx_w;
    chk_flavour_e       flavour;

    // one range comparator per slot against the snooped store
    for (genvar g = 0; g < int'(ENTRIES); g++) begin : g_ov
        ldg_overlap #(.ADDR_W(ADDR_W), .LGSZ_W(LGSZ_W)) u_ov (
            .a_base_i (s_q.base[g]),
            .a_lgsz_i (s_q.lgsz[g]),
            .b_base_i (st_addr_i),
            .b_lgsz_i (st_lgsz_i),
            .hit_o    (st_ov[g])
        );
    end

    assign vld_after_st = st_valid_i ? (s_q.vld & ~st_ov) : s_q.vld;

    // the check looks past this cycle's store
    ldg_tag_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_chk_match (
        .vld_i  (vld_after_st),
        .tags_i (s_q.tag),
        .key_i  (chk_tag_i),
        .hit_o  (chk_hit_w),
        .idx_o  (chk_idx_w)
    );

    ldg_tag_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_ins_match (
        .vld_i  (s_q.vld),
        .tags_i (s_q.tag),
        .key_i  (ins_tag_i),
        .hit_o  (ins_hit_w),
        .idx_o  (ins_idx_w)
    );

    ldg_slot_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_pick (
        .vld_i      (s_q.vld),
        .free_any_o (free_any_w),
        .free_idx_o (free_idx_w)
    );

    assign flavour = chk_flavour_e'(chk_recover_i);

    always_comb begin
        logic [IDX_W-1:0] slot;
        logic             live;

        s_d     = s_q;
        s_d.vld = vld_after_st;
        slot    = '0;
        live    = chk_hit_w && !flush_i;

        s_d.done    = chk_valid_i;
        s_d.hit     = chk_valid_i && live;
        s_d.reload  = chk_valid_i && !live && (flavour == CHK_RELOAD);
        s_d.recover = chk_valid_i && !live && (flavour == CHK_RECOVER);

        if (ins_valid_i) begin
            if (ins_fault_i) begin
                if (ins_hit_w) begin
                    s_d.vld[ins_idx_w] = 1'b0;
                end
            end else begin
                if (ins_hit_w) begin
                    slot = ins_idx_w;
                end else if (free_any_w) begin
                    slot = free_idx_w;
                end else begin
                    slot   = s_q.rr;
                    s_d.rr = (s_q.rr == LAST_IDX) ? '0 : s_q.rr + 1'b1;
                end
                s_d.vld[slot]  = 1'b1;
                s_d.tag[slot]  = ins_tag_i;
                s_d.base[slot] = ins_addr_i;
                s_d.lgsz[slot] = ins_lgsz_i;
            end
        end

        if (flush_i) begin
            s_d.vld = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign chk_done_o    = s_q.done;
    assign chk_hit_o     = s_q.hit;
    assign chk_reload_o  = s_q.reload;
    assign chk_recover_o = s_q.recover;

    logic unused_w;
    assign unused_w = ^chk_idx_w;
endmodule

// File: rtl/ldg_checks.sv
module ldg_checks #(
    parameter int unsigned TAG_W = 7
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             flush_i,
    input logic             ins_valid_i,
    input logic             ins_fault_i,
    input logic [TAG_W-1:0] ins_tag_i,
    input logic             chk_valid_i,
    input logic             chk_recover_i,
    input logic [TAG_W-1:0] chk_tag_i,
    input logic             chk_done_o,
    input logic             chk_hit_o,
    input logic             chk_reload_o,
    input logic             chk_recover_o
);
    a_r2_resp_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chk_valid_i |=> chk_done_o);

    a_r2_quiet_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !chk_valid_i |=> (!chk_done_o && !chk_hit_o && !chk_reload_o && !chk_recover_o));

    a_r5_hit_no_action: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (chk_done_o && chk_hit_o) |-> (!chk_reload_o && !chk_recover_o));

    a_r5_miss_one_action: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (chk_done_o && !chk_hit_o) |-> $onehot({chk_reload_o, chk_recover_o}));

    a_r5_flavour_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (chk_valid_i && chk_recover_i) |=> !chk_reload_o);

    a_r10_flush_same_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flush_i && chk_valid_i) |=> !chk_hit_o);

    a_r10_flush_prev_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(flush_i) && chk_valid_i) |=> !chk_hit_o);

    a_r9_fault_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(ins_valid_i && ins_fault_i) && chk_valid_i && (chk_tag_i == $past(ins_tag_i)))
        |=> !chk_hit_o);
endmodule

bind ldaddr_guard ldg_checks #(.TAG_W(TAG_W)) u_ldg_checks (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .flush_i       (flush_i),
    .ins_valid_i   (ins_valid_i),
    .ins_fault_i   (ins_fault_i),
    .ins_tag_i     (ins_tag_i),
    .chk_valid_i   (chk_valid_i),
    .chk_recover_i (chk_recover_i),
    .chk_tag_i     (chk_tag_i),
    .chk_done_o    (chk_done_o),
    .chk_hit_o     (chk_hit_o),
    .chk_reload_o  (chk_reload_o),
    .chk_recover_o (chk_recover_o)
);

// File: tb/ldaddr_guard_tb_top.sv
module ldaddr_guard_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush;
    logic        ins_v, ins_f;
    logic [6:0]  ins_tag;
    logic [63:0] ins_addr;
    logic [3:0]  ins_lg;
    logic        st_v;
    logic [63:0] st_addr;
    logic [3:0]  st_lg;
    logic        chk_v, chk_m;
    logic [6:0]  chk_tag;
    logic        done_o, hit_o, reload_o, recover_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    ldaddr_guard dut_i (
        .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
        .ins_valid_i(ins_v), .ins_fault_i(ins_f), .ins_tag_i(ins_tag),
        .ins_addr_i(ins_addr), .ins_lgsz_i(ins_lg),
        .st_valid_i(st_v), .st_addr_i(st_addr), .st_lgsz_i(st_lg),
        .chk_valid_i(chk_v), .chk_recover_i(chk_m), .chk_tag_i(chk_tag),
        .chk_done_o(done_o), .chk_hit_o(hit_o),
        .chk_reload_o(reload_o), .chk_recover_o(recover_o)
    );

    // op: 0 insert, 1 store, 2 check, 3 flush; flag = fault (insert) or flavour (check)
    typedef struct packed {
        logic [1:0]  op;
        logic [6:0]  tag;
        logic [31:0] addr;
        logic [3:0]  lg;
        logic        flag;
        logic        exp_hit;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 7'd5,  32'h0000_0100, 4'd3,  1'b0, 1'b0, 4'd2},  // R2 insert 100..107
        '{2'd2, 7'd5,  32'h0,         4'd0,  1'b0, 1'b1, 4'd2},  // R2 hit
        '{2'd2, 7'd5,  32'h0,         4'd0,  1'b1, 1'b1, 4'd5},  // R5 hit, recovery flavour
        '{2'd1, 7'd0,  32'h0000_0108, 4'd3,  1'b0, 1'b0, 4'd4},  // R4 touches top end
        '{2'd2, 7'd5,  32'h0,         4'd0,  1'b0, 1'b1, 4'd4},
        '{2'd1, 7'd0,  32'h0000_00F8, 4'd3,  1'b0, 1'b0, 4'd4},  // R4 touches bottom end
        '{2'd2, 7'd5,  32'h0,         4'd0,  1'b0, 1'b1, 4'd4},
        '{2'd1, 7'd0,  32'h0000_0107, 4'd0,  1'b0, 1'b0, 4'd3},  // R3 last byte only
        '{2'd2, 7'd5,  32'h0,         4'd0,  1'b0, 1'b0, 4'd3},
        '{2'd2, 7'd5,  32'h0,         4'd0,  1'b1, 1'b0, 4'd5},  // R5 miss, recovery
        '{2'd0, 7'd9,  32'h0000_1000, 4'd12, 1'b0, 1'b0, 4'd3},  // 1000..1FFF
        '{2'd1, 7'd0,  32'h0000_1FFE, 4'd1,  1'b0, 1'b0, 4'd3},  // R3 store inside
        '{2'd2, 7'd9,  32'h0,         4'd0,  1'b0, 1'b0, 4'd3},
        '{2'd0, 7'd9,  32'h0000_0300, 4'd2,  1'b0, 1'b0, 4'd6},  // R6 first range
        '{2'd0, 7'd9,  32'h0000_0400, 4'd2,  1'b0, 1'b0, 4'd6},  // R6 overwrite
        '{2'd1, 7'd0,  32'h0000_0300, 4'd2,  1'b0, 1'b0, 4'd6},  // old range only
        '{2'd2, 7'd9,  32'h0,         4'd0,  1'b0, 1'b1, 4'd6},
        '{2'd1, 7'd0,  32'h0000_0402, 4'd0,  1'b0, 1'b0, 4'd6},  // new range
        '{2'd2, 7'd9,  32'h0,         4'd0,  1'b0, 1'b0, 4'd6},
        '{2'd0, 7'd3,  32'h0000_5004, 4'd2,  1'b0, 1'b0, 4'd3},
        '{2'd1, 7'd0,  32'h0000_5000, 4'd4,  1'b0, 1'b0, 4'd3},  // R3 store covers record
        '{2'd2, 7'd3,  32'h0,         4'd0,  1'b1, 1'b0, 4'd3},
        '{2'd2, 7'd77, 32'h0,         4'd0,  1'b0, 1'b0, 4'd5},  // R5 never inserted
        '{2'd0, 7'd11, 32'h0000_0600, 4'd0,  1'b0, 1'b0, 4'd10},
        '{2'd2, 7'd11, 32'h0,         4'd0,  1'b0, 1'b1, 4'd10},
        '{2'd3, 7'd0,  32'h0,         4'd0,  1'b0, 1'b0, 4'd10}, // R10 flush
        '{2'd2, 7'd11, 32'h0,         4'd0,  1'b0, 1'b0, 4'd10}
    };

    task automatic idle_inputs();
        flush = 0; ins_v = 0; ins_f = 0; ins_tag = 0; ins_addr = 0; ins_lg = 0;
        st_v = 0; st_addr = 0; st_lg = 0; chk_v = 0; chk_m = 0; chk_tag = 0;
    endtask

    // drive at falling edge, sample 1 ns after the capturing rising edge
    task automatic cyc(input logic iv, input logic ifl, input logic [6:0] it,
                       input logic [63:0] ia, input logic [3:0] il,
                       input logic sv, input logic [63:0] sa, input logic [3:0] sl,
                       input logic cv, input logic cm, input logic [6:0] ct,
                       input logic fl);
        @(negedge clk);
        ins_v = iv; ins_f = ifl; ins_tag = it; ins_addr = ia; ins_lg = il;
        st_v = sv; st_addr = sa; st_lg = sl;
        chk_v = cv; chk_m = cm; chk_tag = ct; flush = fl;
        @(posedge clk);
        #1;
        idle_inputs();
    endtask

    task automatic expect_resp(input int req, input logic exp_hit, input logic mode);
        logic [3:0] act, exp;
        act = {done_o, hit_o, reload_o, recover_o};
        exp = {1'b1, exp_hit, !exp_hit && !mode, !exp_hit && mode};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: {done,hit,reload,recover} actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic ins(input logic [6:0] t, input logic [63:0] a, input logic [3:0] l);
        cyc(1, 0, t, a, l, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic chk(input int req, input logic [6:0] t, input logic exp_hit);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, t, 0);
        expect_resp(req, exp_hit, 1'b0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        idle_inputs();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 outputs quiet after reset
        n_checks++;
        if ({done_o, hit_o, reload_o, recover_o} !== 4'b0000) begin
            n_fail++;
            $display("FAIL R1: outputs actual %b expected 0000",
                     {done_o, hit_o, reload_o, recover_o});
        end
        chk(1, 7'd0, 1'b0);   // R1 empty table misses

        for (int k = 0; k < NV; k++) begin
            case (VECS[k].op)
                2'd0: cyc(1, VECS[k].flag, VECS[k].tag, {32'b0, VECS[k].addr}, VECS[k].lg,
                          0, 0, 0, 0, 0, 0, 0);
                2'd1: cyc(0, 0, 0, 0, 0, 1, {32'b0, VECS[k].addr}, VECS[k].lg,
                          0, 0, 0, 0);
                2'd2: begin
                    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, VECS[k].flag, VECS[k].tag, 0);
                    expect_resp(int'(VECS[k].req), VECS[k].exp_hit, VECS[k].flag);
                end
                default: cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
            endcase
        end

        // R7 fill all slots, then evict twice round-robin
        for (int t = 20; t < 36; t++) ins(7'(t), 64'h8000 + 64'(t) * 64'h10, 4'd2);
        chk(7, 7'd20, 1'b1);
        chk(7, 7'd35, 1'b1);
        ins(7'd40, 64'h9000, 4'd2);
        chk(7, 7'd20, 1'b0);
        chk(7, 7'd21, 1'b1);
        chk(7, 7'd40, 1'b1);
        ins(7'd41, 64'h9100, 4'd2);
        chk(7, 7'd21, 1'b0);
        chk(7, 7'd22, 1'b1);

        // R10 flush with a same-cycle check
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 7'd22, 1);
        expect_resp(10, 1'b0, 1'b0);

        // R8 store and check together: removal first
        ins(7'd50, 64'h800, 4'd2);
        cyc(0, 0, 0, 0, 0, 1, 64'h801, 4'd0, 1, 1, 7'd50, 0);
        expect_resp(8, 1'b0, 1'b1);

        // R11 insert and check of same tag together: check sees old state
        cyc(1, 0, 7'd60, 64'hB00, 4'd3, 0, 0, 0, 1, 0, 7'd60, 0);
        expect_resp(11, 1'b0, 1'b0);
        chk(11, 7'd60, 1'b1);

        // R12 insert and overlapping store together: record survives
        cyc(1, 0, 7'd61, 64'h900, 4'd3, 1, 64'h900, 4'd3, 0, 0, 0, 0);
        chk(12, 7'd61, 1'b1);

        // R9 faulting insert drops a present tag and adds nothing for an absent one
        ins(7'd62, 64'hA00, 4'd2);
        chk(9, 7'd62, 1'b1);
        cyc(1, 1, 7'd62, 64'hA00, 4'd2, 0, 0, 0, 0, 0, 0, 0);
        chk(9, 7'd62, 1'b0);
        cyc(1, 1, 7'd63, 64'hC00, 4'd2, 0, 0, 0, 0, 0, 0, 0);
        chk(9, 7'd63, 1'b0);

        finish_run();
    end
endmodule